// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits between an interrupt source controller and one processor. It holds a single pending external interrupt and weighs it against two things: the processor's current priority and a register that requests an inter-processor interrupt (IPI). Priorities are 8-bit values. A lower number is more favored, and 0xFF means "none". When an interrupt wins, the block raises a level line to the processor. Any interrupt that is refused, or that loses its slot to a better one, goes back to its source on a reject port.

Software uses the block through a few operations:
- It accepts the pending interrupt by reading the 32-bit status word.
- It changes its own priority.
- It programs the IPI priority.
- It signals end-of-interrupt (EOI) with a full status word. The EOI is passed on to the source controller, followed by a resend request so the sources can present again.

The block performs exactly one operation per clock. All results are registered and appear one cycle later.

Top module: `irq_present_ctl`

## Requirements
- R1: After reset the status word is 0x00000000, the pending priority is 0xFF, the IPI priority is 0xFF, and the line and all pulse outputs are low. A later write of current priority 0xFF therefore latches no IPI.
- R2: `stat_word[31:24]` is the current priority and `stat_word[23:0]` is the pending source number. Source 0 means nothing is pending. `irq_o` is high exactly when the pending source number is non-zero.
- R3: A presented source is refused in two cases: its priority is not strictly below the current priority, or something is pending at an equal or lower priority value. A refused source appears on `rej_num` with `rej_vld` high one cycle later, and the pending state does not change.
- R4: A presented source that is not refused is latched with its priority, and `irq_o` is high in the next cycle. A source pending before it is rejected in that same cycle.
- R5: A write of IPI priority P stores P. If P is strictly below the current priority, an IPI check runs. The check latches the reserved source number 2 with priority P, raises the line, and rejects any source it displaces.
- R6: The IPI check does nothing when a source is pending at a priority value less than or equal to the IPI priority.
- R7: An accept read takes `stat_word` in its cycle. In the next cycle:
  - the line is low;
  - the current priority equals the old pending priority;
  - the source field is zero;
  - the pending priority is 0xFF.
- R8: A write of current priority C below the old value is handled as follows. If a source is pending and C is less than or equal to its priority, the source is cleared and rejected, and the line drops. Otherwise only the priority changes.
- R9: A write of current priority C above the old value raises `rsnd_vld` for one cycle. In the same cycle it runs the IPI check if the IPI priority is below C. A write equal to the old value changes nothing else.
- R10: An EOI write of word W does three things, all seen in the next cycle:
  - the current priority becomes W[31:24];
  - `eoi_vld` pulses with `eoi_num` = W[23:0];
  - `rsnd_vld` pulses, with the IPI check run if the IPI priority is below W[31:24].
- R11: At most one of `src_vld`, `ipi_wr`, `cpri_wr`, `eoi_wr` and `acc_rd` may be high in a cycle. Every pulse output lasts exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_vld | input | 1 | Source presentation strobe |
| src_num | input | 24 | Presented source number |
| src_pri | input | 8 | Presented source priority |
| cpri_wr | input | 1 | Current-priority write strobe |
| cpri_data | input | 8 | New current priority |
| ipi_wr | input | 1 | IPI-priority write strobe |
| ipi_data | input | 8 | New IPI priority |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | Word written with the EOI |
| acc_rd | input | 1 | Accept read strobe |
| stat_word | output | 32 | Status word: priority and pending source |
| irq_o | output | 1 | Level interrupt to the processor |
| rej_vld | output | 1 | Reject pulse |
| rej_num | output | 24 | Rejected source number |
| eoi_vld | output | 1 | EOI pulse to the source controller |
| eoi_num | output | 24 | Source number carried by the EOI |
| rsnd_vld | output | 1 | Resend request pulse |

## Verification
Two functions can land in the same cycle.

The first is displacement. The reject of the displaced source and the latch of its replacement happen together. The bench provokes this by presenting a better source over a pending one, and by letting an IPI check fire over a pending source.

The second is a resend that triggers an IPI check. An EOI or a priority lowering can give one cycle that carries a resend pulse, an EOI pulse, a new IPI latch and a raised line together. The bench sets this up by leaving the IPI priority below the value being written.

The behavioural model predicts every output in the same cycle. Any pulse that appears one cycle early or late, or that is missing from a combined cycle, therefore mismatches.

// File: rtl/irq_present_ctl.sv
module irq_present_ctl #(
  parameter int SRC_W = 24,
  parameter int PRI_W = 8,
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   src_vld,
  input  logic [SRC_W-1:0]       src_num,
  input  logic [PRI_W-1:0]       src_pri,
  input  logic                   cpri_wr,
  input  logic [PRI_W-1:0]       cpri_data,
  input  logic                   ipi_wr,
  input  logic [PRI_W-1:0]       ipi_data,
  input  logic                   eoi_wr,
  input  logic [SRC_W+PRI_W-1:0] eoi_data,
  input  logic                   acc_rd,
  output logic [SRC_W+PRI_W-1:0] stat_word,
  output logic                   irq_o,
  output logic                   rej_vld,
  output logic [SRC_W-1:0]       rej_num,
  output logic                   eoi_vld,
  output logic [SRC_W-1:0]       eoi_num,
  output logic                   rsnd_vld
);

  localparam int WORD_W = SRC_W + PRI_W;
  localparam logic [PRI_W-1:0] PRI_NONE = '1;

  logic [PRI_W-1:0] cppr, ppri, mfrr;
  logic [SRC_W-1:0] xisr;
  logic             irq_q;

  logic [PRI_W-1:0] n_cppr, n_ppri, n_mfrr;
  logic [SRC_W-1:0] n_xisr;
  logic             n_irq, n_rv, n_ev, n_rs, do_ipi;
  logic [SRC_W-1:0] n_rn, n_en;
  logic [PRI_W-1:0] eoi_pri;

  assign eoi_pri   = eoi_data[WORD_W-1:SRC_W];
  assign stat_word = {cppr, xisr};
  assign irq_o     = irq_q;

  always_comb begin
    n_cppr = cppr;
    n_ppri = ppri;
    n_mfrr = mfrr;
    n_xisr = xisr;
    n_irq  = irq_q;
    n_rv   = 1'b0;
    n_rn   = '0;
    n_ev   = 1'b0;
    n_en   = '0;
    n_rs   = 1'b0;
    do_ipi = 1'b0;
    if (src_vld) begin
      if (src_pri >= cppr || (xisr != '0 && ppri <= src_pri)) begin
        n_rv = 1'b1;
        n_rn = src_num;
      end else begin
        if (xisr != '0) begin
          n_rv = 1'b1;
          n_rn = xisr;
        end
        n_xisr = src_num;
        n_ppri = src_pri;
        n_irq  = 1'b1;
      end
    end else if (ipi_wr) begin
      n_mfrr = ipi_data;
      do_ipi = ipi_data < cppr;
    end else if (acc_rd) begin
      n_irq  = 1'b0;
      n_cppr = ppri;
      n_xisr = '0;
      n_ppri = PRI_NONE;
    end else if (cpri_wr) begin
      n_cppr = cpri_data;
      if (cpri_data < cppr) begin
        if (xisr != '0 && cpri_data <= ppri) begin
          n_rv   = 1'b1;
          n_rn   = xisr;
          n_xisr = '0;
          n_ppri = PRI_NONE;
          n_irq  = 1'b0;
        end
      end else if (cpri_data > cppr) begin
        do_ipi = mfrr < cpri_data;
        n_rs   = 1'b1;
      end
    end else if (eoi_wr) begin
      n_cppr = eoi_pri;
      n_ev   = 1'b1;
      n_en   = eoi_data[SRC_W-1:0];
      do_ipi = mfrr < eoi_pri;
      n_rs   = 1'b1;
    end
    if (do_ipi && !(n_xisr != '0 && n_ppri <= n_mfrr)) begin
      if (n_xisr != '0) begin
        n_rv = 1'b1;
        n_rn = n_xisr;
      end
      n_xisr = IPI_SRC;
      n_ppri = n_mfrr;
      n_irq  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr     <= '0;
      ppri     <= PRI_NONE;
      mfrr     <= PRI_NONE;
      xisr     <= '0;
      irq_q    <= 1'b0;
      rej_vld  <= 1'b0;
      rej_num  <= '0;
      eoi_vld  <= 1'b0;
      eoi_num  <= '0;
      rsnd_vld <= 1'b0;
    end else begin
      cppr     <= n_cppr;
      ppri     <= n_ppri;
      mfrr     <= n_mfrr;
      xisr     <= n_xisr;
      irq_q    <= n_irq;
      rej_vld  <= n_rv;
      rej_num  <= n_rn;
      eoi_vld  <= n_ev;
      eoi_num  <= n_en;
      rsnd_vld <= n_rs;
    end
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({src_vld, ipi_wr, acc_rd, cpri_wr, eoi_wr}) <= 1); // R11

  AST_LINE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (stat_word[SRC_W-1:0] != '0)); // R2

  AST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    src_vld && (src_pri >= cppr) |=> rej_vld && rej_num == $past(src_num) && $stable(xisr)); // R3

  AST_IPI_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_wr && (ipi_data < cppr) && (xisr == '0 || ppri > ipi_data)
    |=> irq_o && xisr == IPI_SRC && ppri == $past(ipi_data)); // R5

  AST_ACC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> !irq_o && xisr == '0 && ppri == PRI_NONE && cppr == $past(ppri)); // R7

  AST_EOI_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> eoi_vld && rsnd_vld && eoi_num == $past(eoi_data[SRC_W-1:0])); // R10

  AST_RSND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsnd_vld |-> $past(eoi_wr) || ($past(cpri_wr) && ($past(cpri_data) > $past(cppr)))); // R9

endmodule

// File: tb/irq_present_ctl_bench.sv
`timescale 1ns/1ps
module irq_present_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_vld = 0, cpri_wr = 0, ipi_wr = 0, eoi_wr = 0, acc_rd = 0;
  logic [23:0] src_num = '0;
  logic [7:0]  src_pri = '0, cpri_data = '0, ipi_data = '0;
  logic [31:0] eoi_data = '0;
  logic [31:0] stat_word;
  logic irq_o, rej_vld, eoi_vld, rsnd_vld;
  logic [23:0] rej_num, eoi_num;

  always #2.5 clk = ~clk;

  irq_present_ctl u_irq_present_ctl (
    .clk(clk), .rst_n(rst_n),
    .src_vld(src_vld), .src_num(src_num), .src_pri(src_pri),
    .cpri_wr(cpri_wr), .cpri_data(cpri_data),
    .ipi_wr(ipi_wr), .ipi_data(ipi_data),
    .eoi_wr(eoi_wr), .eoi_data(eoi_data),
    .acc_rd(acc_rd),
    .stat_word(stat_word), .irq_o(irq_o),
    .rej_vld(rej_vld), .rej_num(rej_num),
    .eoi_vld(eoi_vld), .eoi_num(eoi_num),
    .rsnd_vld(rsnd_vld)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  int m_cppr, m_ppri, m_mfrr, m_xisr, m_irq;
  int e_rv, e_rn, e_ev, e_en, e_rs;

  task automatic m_ipi_check();
    if (m_xisr != 0 && m_ppri <= m_mfrr) return;
    if (m_xisr != 0) begin e_rv = 1; e_rn = m_xisr; end
    m_xisr = 2; m_ppri = m_mfrr; m_irq = 1;
  endtask

  task automatic m_resend();
    if (m_mfrr < m_cppr) m_ipi_check();
    e_rs = 1;
  endtask

  always @(posedge clk) begin
    e_rv = 0; e_rn = 0; e_ev = 0; e_en = 0; e_rs = 0;
    if (!rst_n) begin
      m_cppr = 0; m_ppri = 255; m_mfrr = 255; m_xisr = 0; m_irq = 0;
    end else if (src_vld) begin
      if (int'(src_pri) >= m_cppr || (m_xisr != 0 && m_ppri <= int'(src_pri))) begin
        e_rv = 1; e_rn = int'(src_num);
      end else begin
        if (m_xisr != 0) begin e_rv = 1; e_rn = m_xisr; end
        m_xisr = int'(src_num); m_ppri = int'(src_pri); m_irq = 1;
      end
    end else if (ipi_wr) begin
      m_mfrr = int'(ipi_data);
      if (m_mfrr < m_cppr) m_ipi_check();
    end else if (acc_rd) begin
      m_irq = 0; m_cppr = m_ppri; m_xisr = 0; m_ppri = 255;
    end else if (cpri_wr) begin
      int old;
      old = m_cppr;
      m_cppr = int'(cpri_data);
      if (m_cppr < old) begin
        if (m_xisr != 0 && m_cppr <= m_ppri) begin
          e_rv = 1; e_rn = m_xisr; m_xisr = 0; m_ppri = 255; m_irq = 0;
        end
      end else if (m_cppr > old) m_resend();
    end else if (eoi_wr) begin
      m_cppr = int'(eoi_data[31:24]);
      e_ev = 1; e_en = int'(eoi_data[23:0]);
      m_resend();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "stat_word", int'(stat_word), (m_cppr << 24) | m_xisr);
    chk(req, "irq_o", int'(irq_o), m_irq);
    chk(req, "rej_vld", int'(rej_vld), e_rv);
    chk(req, "rej_num", int'(rej_num), e_rn);
    chk(req, "eoi_vld", int'(eoi_vld), e_ev);
    chk(req, "eoi_num", int'(eoi_num), e_en);
    chk(req, "rsnd_vld", int'(rsnd_vld), e_rs);
  endtask

  task automatic step(input string req);
    @(posedge clk);
    #1;
    compare(req);
    src_vld = 0; cpri_wr = 0; ipi_wr = 0; eoi_wr = 0; acc_rd = 0;
  endtask

  task automatic do_src(input int n, input int p, input string req);
    src_vld = 1; src_num = 24'(n); src_pri = 8'(p); step(req);
  endtask
  task automatic do_cpri(input int p, input string req);
    cpri_wr = 1; cpri_data = 8'(p); step(req);
  endtask
  task automatic do_ipi(input int p, input string req);
    ipi_wr = 1; ipi_data = 8'(p); step(req);
  endtask
  task automatic do_eoi(input int w, input string req);
    eoi_wr = 1; eoi_data = 32'(w); step(req);
  endtask
  task automatic do_acc(input string req);
    acc_rd = 1; step(req);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step("R1");
    do_src(5, 5, "R3");                 // cppr 0 refuses all
    do_cpri(255, "R1");                 // IPI priority 0xFF: resend, no IPI
    do_src(16, 8, "R4");
    step("R2");
    do_src(17, 4, "R4");                // displaces 16
    do_src(18, 4, "R3");                // equal to pending
    do_src(19, 9, "R3");
    do_acc("R7");
    do_eoi(32'hFF000011, "R10");
    do_ipi(6, "R5");
    step("R2");
    do_src(32, 3, "R4");                // displaces IPI
    do_ipi(7, "R6");                    // pending 3 <= 7: skipped
    do_cpri(2, "R8");                   // clears and rejects 32
    do_cpri(255, "R9");                 // resend plus IPI latch
    do_src(48, 1, "R4");
    do_cpri(5, "R8");                   // 5 > 1: keeps pending
    do_cpri(5, "R9");                   // equal: nothing
    do_acc("R7");
    do_eoi(32'h05000030, "R10");
    do_eoi(32'hFF000000, "R10");        // EOI, resend and IPI in one cycle
    do_ipi(0, "R5");                    // displaces IPI with IPI
    for (int i = 0; i < 500; i++) begin
      int k;
      int pr;
      k = $urandom % 6;
      pr = ($urandom % 8 == 0) ? 255 : int'($urandom % 16);
      case (k)
        0: do_src(1 + int'($urandom % 15), pr, "R11");
        1: do_cpri(pr, "R11");
        2: do_ipi(pr, "R11");
        3: do_eoi((pr << 24) | int'($urandom % 16), "R11");
        4: do_acc("R11");
        default: step("R11");
      endcase
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule